// File: doc/BRIEF.md
# Transceiver Channel Protection-Entry Sequencer

This block walks one transceiver channel from its normal operating configuration into a parked, self-looped protection configuration. A single-cycle start pulse launches the run. The block holds the channel in reset and waits for the channel to report not-ready. It then sends a series of attribute commands, each a 16-bit code with 16-bit data, to a command engine. Between these commands it performs direct byte accesses. One group of accesses resets the channel's internal controller through a mailbox. Another group edits three clock-setup bytes with read-modify-write, and the original value of each byte is kept for a later return to normal operation.

The run ends when the channel is re-enabled, the PMA reports ready again and an adaptation request pulse is issued. A command that reports an error aborts the run, and so does any wait that outlasts a programmable cycle limit. An abort raises a sticky error flag that stays set until the next accepted start. The reference-clock multiplier used in the two rate commands is an input. It is captured when a start is accepted.

Top module: `prot_entry_seq`

## Requirements
- R1: After reset, busy, done, errorFlag, chanReset, cmdValid, regReq and adaptStart are all low.
- R2: chanReset is high for the whole of a run. No command and no byte access is issued until chanReady has been observed low.
- R3: Seven commands are issued, one at a time and in this order, as code/data pairs: 0001/0000, 0014/0055, 0005/M, 0006/M, 0002/0120, 0008/0101, 0001/0003. Each is held stable until cmdDone.
- R4: M is {refMult, refMult}, using the refMult value sampled in the cycle the start is accepted. For example, refMult 0x10 gives data 0x1010.
- R5: After the first command, the block waits for pmaReady low. It then writes bytes 00, 00, 00, 81 to addresses 0x200, 0x201, 0x202, 0x203 in that order. Next it reads 0x207 repeatedly until a read returns 0x80, and only then issues the 0014 command.
- R6: After the 0008 command, the block does a read then a write of address 0x038, then 0x007, then 0x005. The written values are: 0x038 with bits 1:0 forced to 01; 0x007 with bits 7 and 1 cleared; 0x005 with bits 7:2 forced to 000010. All other bits keep the value that was read.
- R7: The values read from 0x038, 0x007 and 0x005 appear on savedIfDcc, savedRxClk and savedTxClk. They stay there until the next run reads them again.
- R8: After the final command, the block waits for pmaReady high. adaptStart and done then pulse together for one cycle, exactly once per completed run.
- R9: A cmdDone with cmdErr high aborts the run. errorFlag rises, busy falls, and no further command or access is issued.
- R10: A wait that gets no response within TIMEOUT_CYC+1 cycles of its step starting aborts the run as in R9. A response in the last allowed cycle still counts as success.
- R11: A start pulse arriving while busy is high has no effect. This includes a start in the cycle where done pulses.
- R12: errorFlag stays high after an abort and is cleared by the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startPulse | input | 1 | Launches a run when idle |
| refMult | input | 8 | Reference-clock multiplier for the rate commands |
| chanReady | input | 1 | Channel ready status |
| pmaReady | input | 1 | PMA ready status |
| chanReset | output | 1 | TX/RX reset request to the channel |
| cmdValid | output | 1 | Attribute command request |
| cmdCode | output | 16 | Attribute code |
| cmdData | output | 16 | Attribute data |
| cmdDone | input | 1 | Command completion |
| cmdErr | input | 1 | Command failed, valid with cmdDone |
| regReq | output | 1 | Byte access request |
| regWrite | output | 1 | 1 = write, 0 = read |
| regAddr | output | 12 | Byte address |
| regWdata | output | 8 | Write byte |
| regAck | input | 1 | Access completion |
| regRdata | input | 8 | Read byte, valid with regAck |
| adaptStart | output | 1 | Initial adaptation request pulse |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| errorFlag | output | 1 | Sticky abort indication |
| savedIfDcc | output | 8 | Saved byte from 0x038 |
| savedRxClk | output | 8 | Saved byte from 0x007 |
| savedTxClk | output | 8 | Saved byte from 0x005 |

## Verification
A new start pulse can coincide with the last cycle of a run, which is the cycle where done and adaptStart pulse. The bench watches for done and raises start in that same cycle. It then confirms that busy stays low, that no further command appears, and that exactly one done was counted. A response can also coincide with the expiry of the wait limit. The bench delays chanReady's fall by exactly TIMEOUT_CYC cycles, and the run must finish. It then delays the fall by one cycle more, and the run must abort before any command is issued.

// File: rtl/prot_pkg.sv
package prot_pkg;

  localparam int ADDR_W = 12;
  localparam int STEP_W = 5;

  typedef enum logic [2:0] {
    OP_RSTWAIT, OP_CMD, OP_PMALO, OP_WR, OP_POLL, OP_RMW, OP_PMAHI, OP_ADAPT
  } opKind_e;

  typedef enum logic [1:0] { ST_IDLE, ST_RUN, ST_RMWWR } seqState_e;

  typedef struct packed {
    opKind_e           kind;
    logic [15:0]       code;
    logic [15:0]       data;
    logic              useMult;
    logic [ADDR_W-1:0] addr;
    logic [7:0]        wdata;
    logic [1:0]        sel;
  } stepDesc_t;

  typedef struct packed {
    logic       clrTimer;
    logic       latchMult;
    logic       saveEn;
    logic [1:0] saveSel;
  } dpStrobe_t;

  function automatic stepDesc_t mkStep(opKind_e k, logic [15:0] c, logic [15:0] d,
                                       logic m, logic [ADDR_W-1:0] a, logic [7:0] w,
                                       logic [1:0] s);
    stepDesc_t r;
    r.kind = k; r.code = c; r.data = d; r.useMult = m;
    r.addr = a; r.wdata = w; r.sel = s;
    return r;
  endfunction

  // The recipe; the order is the behaviour.
  function automatic stepDesc_t stepDesc(logic [STEP_W-1:0] idx);
    case (idx)
      5'd0:  return mkStep(OP_RSTWAIT, 16'h0000, 16'h0000, 1'b0, 12'h000, 8'h00, 2'd0);
      5'd1:  return mkStep(OP_CMD,     16'h0001, 16'h0000, 1'b0, 12'h000, 8'h00, 2'd0);
      5'd2:  return mkStep(OP_PMALO,   16'h0000, 16'h0000, 1'b0, 12'h000, 8'h00, 2'd0);
      5'd3:  return mkStep(OP_WR,      16'h0000, 16'h0000, 1'b0, 12'h200, 8'h00, 2'd0);
      5'd4:  return mkStep(OP_WR,      16'h0000, 16'h0000, 1'b0, 12'h201, 8'h00, 2'd0);
      5'd5:  return mkStep(OP_WR,      16'h0000, 16'h0000, 1'b0, 12'h202, 8'h00, 2'd0);
      5'd6:  return mkStep(OP_WR,      16'h0000, 16'h0000, 1'b0, 12'h203, 8'h81, 2'd0);
      5'd7:  return mkStep(OP_POLL,    16'h0000, 16'h0000, 1'b0, 12'h207, 8'h80, 2'd0);
      5'd8:  return mkStep(OP_CMD,     16'h0014, 16'h0055, 1'b0, 12'h000, 8'h00, 2'd0);
      5'd9:  return mkStep(OP_CMD,     16'h0005, 16'h0000, 1'b1, 12'h000, 8'h00, 2'd0);
      5'd10: return mkStep(OP_CMD,     16'h0006, 16'h0000, 1'b1, 12'h000, 8'h00, 2'd0);
      5'd11: return mkStep(OP_CMD,     16'h0002, 16'h0120, 1'b0, 12'h000, 8'h00, 2'd0);
      5'd12: return mkStep(OP_CMD,     16'h0008, 16'h0101, 1'b0, 12'h000, 8'h00, 2'd0);
      5'd13: return mkStep(OP_RMW,     16'h0000, 16'h0000, 1'b0, 12'h038, 8'h00, 2'd0);
      5'd14: return mkStep(OP_RMW,     16'h0000, 16'h0000, 1'b0, 12'h007, 8'h00, 2'd1);
      5'd15: return mkStep(OP_RMW,     16'h0000, 16'h0000, 1'b0, 12'h005, 8'h00, 2'd2);
      5'd16: return mkStep(OP_CMD,     16'h0001, 16'h0003, 1'b0, 12'h000, 8'h00, 2'd0);
      5'd17: return mkStep(OP_PMAHI,   16'h0000, 16'h0000, 1'b0, 12'h000, 8'h00, 2'd0);
      default: return mkStep(OP_ADAPT, 16'h0000, 16'h0000, 1'b0, 12'h000, 8'h00, 2'd0);
    endcase
  endfunction

endpackage

// File: rtl/prot_seq_dp.sv
module prot_seq_dp
  import prot_pkg::*;
#(
  parameter int TIMEOUT_CYC = 4096,
  parameter int MULT_W      = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [MULT_W-1:0] refMult,
  input  logic [7:0]        regRdata,
  output logic              timedOut,
  output logic [2*MULT_W-1:0] multWord,
  output logic [7:0]        rmwByte,
  output logic [7:0]        savedIfDcc,
  output logic [7:0]        savedRxClk,
  output logic [7:0]        savedTxClk
);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);
  localparam int NUM_SAVED = 3;
  localparam logic [TW-1:0] LIMIT = TW'(TIMEOUT_CYC);

  logic [TW-1:0]     timer;
  logic [MULT_W-1:0] multReg;
  logic [7:0]        savedBytes [NUM_SAVED];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                timer <= '0;
    else if (strobe.clrTimer) timer <= '0;
    else if (timer != LIMIT)  timer <= timer + 1'b1;
  end
  assign timedOut = (timer == LIMIT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 multReg <= '0;
    else if (strobe.latchMult) multReg <= refMult;
  end
  assign multWord = {multReg, multReg};

  for (genvar g = 0; g < NUM_SAVED; g++) begin : gSave
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) savedBytes[g] <= '0;
      else if (strobe.saveEn && strobe.saveSel == 2'(g)) savedBytes[g] <= regRdata;
    end
  end

  assign savedIfDcc = savedBytes[0];
  assign savedRxClk = savedBytes[1];
  assign savedTxClk = savedBytes[2];

  always_comb begin
    unique case (strobe.saveSel)
      2'd0:    rmwByte = (savedBytes[0] & 8'hFC) | 8'h01;
      2'd1:    rmwByte =  savedBytes[1] & 8'h7D;
      default: rmwByte = (savedBytes[2] & 8'h03) | 8'h08;
    endcase
  end

  AST_SAVE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.saveEn |=> $stable(savedIfDcc) && $stable(savedRxClk) && $stable(savedTxClk)); // R7
  AST_MULT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.latchMult |=> $stable(multWord)); // R4

endmodule

// File: rtl/prot_seq_ctrl.sv
module prot_seq_ctrl
  import prot_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic              chanReady,
  input  logic              pmaReady,
  input  logic              cmdDone,
  input  logic              cmdErr,
  input  logic              regAck,
  input  logic [7:0]        regRdata,
  input  logic              timedOut,
  input  logic [15:0]       multWord,
  input  logic [7:0]        rmwByte,
  output dpStrobe_t         strobe,
  output logic              chanReset,
  output logic              cmdValid,
  output logic [15:0]       cmdCode,
  output logic [15:0]       cmdData,
  output logic              regReq,
  output logic              regWrite,
  output logic [ADDR_W-1:0] regAddr,
  output logic [7:0]        regWdata,
  output logic              adaptStart,
  output logic              busy,
  output logic              done,
  output logic              errorFlag
);
  seqState_e         state;
  logic [STEP_W-1:0] stepIdx;
  stepDesc_t         desc;
  logic stepDone, stepFail, rdAck, progress, abort, accept;

  assign busy      = (state != ST_IDLE);
  assign chanReset = busy;
  assign accept    = (state == ST_IDLE) && startPulse;

  always_comb begin
    desc       = stepDesc(stepIdx);
    cmdValid   = 1'b0;
    cmdCode    = desc.code;
    cmdData    = desc.useMult ? multWord : desc.data;
    regReq     = 1'b0;
    regWrite   = 1'b0;
    regAddr    = desc.addr;
    regWdata   = desc.wdata;
    adaptStart = 1'b0;
    done       = 1'b0;
    stepDone   = 1'b0;
    stepFail   = 1'b0;
    rdAck      = 1'b0;
    if (state == ST_RUN) begin
      unique case (desc.kind)
        OP_RSTWAIT: stepDone = !chanReady;
        OP_CMD: begin
          cmdValid = 1'b1;
          stepDone = cmdDone && !cmdErr;
          stepFail = cmdDone && cmdErr;
        end
        OP_PMALO: stepDone = !pmaReady;
        OP_WR: begin
          regReq = 1'b1; regWrite = 1'b1; stepDone = regAck;
        end
        OP_POLL: begin
          regReq = 1'b1; stepDone = regAck && (regRdata == desc.wdata);
        end
        OP_RMW: begin
          regReq = 1'b1; rdAck = regAck;
        end
        OP_PMAHI: stepDone = pmaReady;
        default: begin
          stepDone = 1'b1; adaptStart = 1'b1; done = 1'b1;
        end
      endcase
    end else if (state == ST_RMWWR) begin
      regReq = 1'b1; regWrite = 1'b1; regWdata = rmwByte; stepDone = regAck;
    end
    progress         = stepDone || rdAck;
    abort            = busy && (stepFail || (timedOut && !progress));
    strobe.clrTimer  = progress || accept;
    strobe.latchMult = accept;
    strobe.saveEn    = rdAck;
    strobe.saveSel   = desc.sel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      stepIdx   <= '0;
      errorFlag <= 1'b0;
    end else if (accept) begin
      state     <= ST_RUN;
      stepIdx   <= '0;
      errorFlag <= 1'b0;
    end else if (abort) begin
      state     <= ST_IDLE;
      errorFlag <= 1'b1;
    end else if (rdAck) begin
      state     <= ST_RMWWR;
    end else if (stepDone) begin
      if (state == ST_RUN && desc.kind == OP_ADAPT) state <= ST_IDLE;
      else begin
        state   <= ST_RUN;
        stepIdx <= stepIdx + 1'b1;
      end
    end
  end

  AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rstN)
    !(cmdValid && regReq)); // R3
  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && !cmdDone && !timedOut |=> cmdValid && $stable(cmdCode) && $stable(cmdData)); // R3
  AST_REQ_IN_RESET: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid || regReq) |-> chanReset); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done && !busy); // R8
  AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    busy && cmdValid && cmdDone && cmdErr |=> errorFlag && !busy && !cmdValid && !regReq); // R9
  AST_BUSY_START: assert property (@(posedge clk) disable iff (!rstN)
    busy && startPulse && !done && !abort |=> busy && $stable(errorFlag)); // R11

endmodule

// File: rtl/prot_entry_seq.sv
module prot_entry_seq
  import prot_pkg::*;
#(
  parameter int TIMEOUT_CYC = 4096
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic [7:0]        refMult,
  input  logic              chanReady,
  input  logic              pmaReady,
  output logic              chanReset,
  output logic              cmdValid,
  output logic [15:0]       cmdCode,
  output logic [15:0]       cmdData,
  input  logic              cmdDone,
  input  logic              cmdErr,
  output logic              regReq,
  output logic              regWrite,
  output logic [ADDR_W-1:0] regAddr,
  output logic [7:0]        regWdata,
  input  logic              regAck,
  input  logic [7:0]        regRdata,
  output logic              adaptStart,
  output logic              busy,
  output logic              done,
  output logic              errorFlag,
  output logic [7:0]        savedIfDcc,
  output logic [7:0]        savedRxClk,
  output logic [7:0]        savedTxClk
);
  dpStrobe_t   strobe;
  logic        timedOut;
  logic [15:0] multWord;
  logic [7:0]  rmwByte;

  prot_seq_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .chanReady(chanReady),
    .pmaReady(pmaReady), .cmdDone(cmdDone), .cmdErr(cmdErr), .regAck(regAck),
    .regRdata(regRdata), .timedOut(timedOut), .multWord(multWord), .rmwByte(rmwByte),
    .strobe(strobe), .chanReset(chanReset), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .cmdData(cmdData), .regReq(regReq), .regWrite(regWrite), .regAddr(regAddr),
    .regWdata(regWdata), .adaptStart(adaptStart), .busy(busy), .done(done),
    .errorFlag(errorFlag)
  );

  prot_seq_dp #(.TIMEOUT_CYC(TIMEOUT_CYC), .MULT_W(8)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .refMult(refMult), .regRdata(regRdata),
    .timedOut(timedOut), .multWord(multWord), .rmwByte(rmwByte),
    .savedIfDcc(savedIfDcc), .savedRxClk(savedRxClk), .savedTxClk(savedTxClk)
  );

endmodule

// File: tb/test_prot_entry_seq.sv
module test_prot_entry_seq;
  localparam int TO_LIM = 40;

  logic clk = 1'b0, rstN = 1'b0, startPulse = 1'b0;
  logic [7:0] refMult = '0;
  logic chanReady = 1'b1, pmaReady = 1'b1, cmdDone = 1'b0, cmdErr = 1'b0;
  logic regAck = 1'b0;
  logic [7:0] regRdata = '0;
  logic chanReset, cmdValid, regReq, regWrite, adaptStart, busy, done, errorFlag;
  logic [15:0] cmdCode, cmdData;
  logic [11:0] regAddr;
  logic [7:0] regWdata, savedIfDcc, savedRxClk, savedTxClk;

  always #2 clk = ~clk;

  prot_entry_seq #(.TIMEOUT_CYC(TO_LIM)) i_prot_entry_seq (.*);

  int errCnt = 0, chkCnt = 0, cyc = 0;

  // model configuration, driven by the stimulus process
  int rdyDly, pmaDly, cmdLat, regLat, pollBusy;
  logic [15:0] errCode = 16'hFFFF;
  bit pmaStuck = 0, clearReq = 0;
  logic [7:0] init05, init07, init38;

  // model state and logs, driven by the model process
  logic [7:0] mem [0:1023];
  logic [15:0] logCode [0:15], logData [0:15];
  logic [11:0] wrAddr [0:15];
  logic [7:0]  wrData [0:15];
  int cmdCnt, wrCnt, doneCnt, adaptCnt, rdyCnt, pmaCnt, cmdWait, regWait, pollLeft;
  logic pmaTarget, rdyAtFirstCmd, rstAtFirstCmd, pmaAt200, pmaAtAdapt;

  always @(negedge clk) begin
    if (clearReq) begin
      cmdCnt = 0; wrCnt = 0; doneCnt = 0; adaptCnt = 0; rdyCnt = 0;
      cmdWait = cmdLat; regWait = regLat; pollLeft = pollBusy;
      pmaReady = 1'b1; pmaTarget = 1'b1; pmaCnt = 0;
      mem[12'h005] = init05; mem[12'h007] = init07; mem[12'h038] = init38;
      rdyAtFirstCmd = 1'bx; rstAtFirstCmd = 1'bx; pmaAt200 = 1'bx; pmaAtAdapt = 1'bx;
    end
    if (done) doneCnt++;
    if (adaptStart) begin adaptCnt++; pmaAtAdapt = pmaReady; end
    if (chanReset) begin
      if (chanReady) begin
        if (rdyCnt == rdyDly) chanReady = 1'b0; else rdyCnt++;
      end
    end else begin
      chanReady = 1'b1; rdyCnt = 0;
    end
    if (!pmaStuck && pmaReady != pmaTarget) begin
      if (pmaCnt == 0) pmaReady = pmaTarget; else pmaCnt--;
    end
    if (cmdDone) begin cmdDone = 1'b0; cmdErr = 1'b0; end
    else if (cmdValid) begin
      if (cmdWait == 0) begin
        cmdDone = 1'b1; cmdErr = (cmdCode == errCode);
        if (cmdCnt == 0) begin rdyAtFirstCmd = chanReady; rstAtFirstCmd = chanReset; end
        if (cmdCnt < 16) begin logCode[cmdCnt] = cmdCode; logData[cmdCnt] = cmdData; end
        cmdCnt++;
        if (cmdCode == 16'h0001 && cmdData == 16'h0000) begin pmaTarget = 1'b0; pmaCnt = pmaDly; end
        if (cmdCode == 16'h0001 && cmdData == 16'h0003) begin pmaTarget = 1'b1; pmaCnt = pmaDly; end
        cmdWait = cmdLat;
      end else cmdWait--;
    end
    if (regAck) regAck = 1'b0;
    else if (regReq) begin
      if (regWait == 0) begin
        regAck = 1'b1;
        if (regWrite) begin
          mem[regAddr[9:0]] = regWdata;
          if (regAddr == 12'h200) pmaAt200 = pmaReady;
          if (wrCnt < 16) begin wrAddr[wrCnt] = regAddr; wrData[wrCnt] = regWdata; end
          wrCnt++;
        end else if (regAddr == 12'h207) begin
          regRdata = (pollLeft > 0) ? 8'h00 : 8'h80;
          if (pollLeft > 0) pollLeft--;
        end else regRdata = mem[regAddr[9:0]];
        regWait = regLat;
      end else regWait--;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    chkCnt++;
    if (!ok) begin
      errCnt++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp38(input logic [7:0] v); return (v & 8'hFC) | 8'h01; endfunction
  function automatic logic [7:0] exp07(input logic [7:0] v); return v & 8'h7D; endfunction
  function automatic logic [7:0] exp05(input logic [7:0] v); return (v & 8'h03) | 8'h08; endfunction

  function automatic logic [31:0] expCmd(input int i, input logic [7:0] m);
    case (i)
      0: return 32'h0001_0000;
      1: return 32'h0014_0055;
      2: return {16'h0005, m, m};
      3: return {16'h0006, m, m};
      4: return 32'h0002_0120;
      5: return 32'h0008_0101;
      default: return 32'h0001_0003;
    endcase
  endfunction

  task automatic setup(input logic [7:0] m, input logic [7:0] b05, input logic [7:0] b07,
                       input logic [7:0] b38, input int rd, input int pd, input int cl,
                       input int rl, input int pb);
    refMult = m; init05 = b05; init07 = b07; init38 = b38;
    rdyDly = rd; pmaDly = pd; cmdLat = cl; regLat = rl; pollBusy = pb;
    @(negedge clk); clearReq = 1'b1;
    @(negedge clk); clearReq = 1'b0;
  endtask

  task automatic launchAndWait();
    int n;
    startPulse = 1'b1;
    @(negedge clk); startPulse = 1'b0;
    n = 0;
    while (busy && n < 5000) begin @(negedge clk); n++; end
    @(negedge clk);
  endtask

  task automatic checkGood(input logic [7:0] m, input logic [7:0] b05, input logic [7:0] b07,
                           input logic [7:0] b38);
    logic [11:0] ea [0:6];
    logic [7:0]  ed [0:6];
    ea = '{12'h200, 12'h201, 12'h202, 12'h203, 12'h038, 12'h007, 12'h005};
    ed = '{8'h00, 8'h00, 8'h00, 8'h81, exp38(b38), exp07(b07), exp05(b05)};
    chk(cmdCnt == 7, "R3 command count", cmdCnt, 7);
    for (int i = 0; i < 7 && i < cmdCnt; i++)
      chk({logCode[i], logData[i]} == expCmd(i, m), "R3/R4 command code/data",
          {logCode[i], logData[i]}, expCmd(i, m));
    chk(wrCnt == 7, "R5/R6 write count", wrCnt, 7);
    for (int i = 0; i < 7 && i < wrCnt; i++)
      chk(wrAddr[i] == ea[i] && wrData[i] == ed[i], "R5/R6 write addr/data",
          {wrAddr[i], wrData[i]}, {ea[i], ed[i]});
    chk(rdyAtFirstCmd === 1'b0 && rstAtFirstCmd === 1'b1, "R2 ready low before first command",
        {rdyAtFirstCmd, rstAtFirstCmd}, 2'b01);
    chk(pmaAt200 === 1'b0, "R5 pma low before mailbox", pmaAt200, 0);
    chk({savedIfDcc, savedRxClk, savedTxClk} == {b38, b07, b05}, "R7 saved bytes",
        {savedIfDcc, savedRxClk, savedTxClk}, {b38, b07, b05});
    chk(doneCnt == 1 && adaptCnt == 1 && pmaAtAdapt === 1'b1, "R8 single done with adapt",
        {doneCnt[7:0], adaptCnt[7:0]}, 16'h0101);
    chk(!errorFlag && !busy && !chanReset, "R8 clean finish", {errorFlag, busy, chanReset}, 0);
  endtask

  initial begin
    logic [7:0] m, b05, b07, b38;
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    chk({busy, done, errorFlag, chanReset, cmdValid, regReq, adaptStart} == 0, "R1 reset state",
        {busy, done, errorFlag, chanReset, cmdValid, regReq, adaptStart}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // directed: multiplier 16, all-ones and all-zeros bytes
    setup(8'h10, 8'hFF, 8'hFF, 8'h00, 2, 3, 1, 1, 2);
    launchAndWait();
    checkGood(8'h10, 8'hFF, 8'hFF, 8'h00);
    chk({logData[2], logData[3]} == 32'h1010_1010, "R4 multiplier 16",
        {logData[2], logData[3]}, 32'h1010_1010);

    // random runs
    for (int r = 0; r < 6; r++) begin
      m = 8'($urandom); b05 = 8'($urandom); b07 = 8'($urandom); b38 = 8'($urandom);
      setup(m, b05, b07, b38, $urandom % 11, $urandom % 11, $urandom % 6,
            $urandom % 4, $urandom % 5);
      launchAndWait();
      checkGood(m, b05, b07, b38);
    end

    // start while busy, refMult change after capture, start in the done cycle
    setup(8'h21, 8'h5A, 8'hA5, 8'h3C, 1, 2, 2, 1, 1);
    startPulse = 1'b1; @(negedge clk); startPulse = 1'b0;
    refMult = 8'h77;
    repeat (20) @(negedge clk);
    startPulse = 1'b1; @(negedge clk); startPulse = 1'b0;
    while (!done && busy) @(negedge clk);
    startPulse = 1'b1; @(negedge clk); startPulse = 1'b0;
    repeat (5) @(negedge clk);
    chk(!busy && cmdCnt == 7 && doneCnt == 1, "R11 start while busy ignored",
        {busy, cmdCnt[7:0], doneCnt[7:0]}, {1'b0, 8'd7, 8'd1});
    checkGood(8'h21, 8'h5A, 8'hA5, 8'h3C);

    // command error on the RX rate command
    errCode = 16'h0006;
    setup(8'h10, 8'h00, 8'h00, 8'h00, 0, 1, 0, 0, 0);
    launchAndWait();
    errCode = 16'hFFFF;
    chk(errorFlag && !busy, "R9 error raised", {errorFlag, busy}, 2'b10);
    chk(cmdCnt == 4 && wrCnt == 4 && doneCnt == 0, "R9 nothing after abort",
        {cmdCnt[7:0], wrCnt[7:0], doneCnt[7:0]}, {8'd4, 8'd4, 8'd0});
    repeat (4) @(negedge clk);
    chk(errorFlag, "R12 error sticky", errorFlag, 1);

    // timeout boundary on the first wait
    setup(8'h09, 8'h12, 8'h34, 8'h56, TO_LIM, 0, 0, 0, 0);
    launchAndWait();
    chk(!errorFlag, "R12 start clears error / R10 last allowed cycle", errorFlag, 0);
    checkGood(8'h09, 8'h12, 8'h34, 8'h56);
    setup(8'h09, 8'h12, 8'h34, 8'h56, TO_LIM + 1, 0, 0, 0, 0);
    launchAndWait();
    chk(errorFlag && cmdCnt == 0, "R10 timeout one cycle late", {errorFlag, cmdCnt[7:0]}, {1'b1, 8'd0});

    // PMA never drops
    pmaStuck = 1'b1;
    setup(8'h09, 8'h12, 8'h34, 8'h56, 0, 0, 0, 0, 0);
    launchAndWait();
    pmaStuck = 1'b0;
    chk(errorFlag && cmdCnt == 1 && wrCnt == 0, "R10 stuck pma timeout",
        {errorFlag, cmdCnt[7:0], wrCnt[7:0]}, {1'b1, 8'd1, 8'd0});

    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errCnt++; chkCnt++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
      $finish;
    end
  end

endmodule